// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. It runs the sample/hold switch and drives the code of an external DAC. It reads a single comparator decision on each bit trial and builds a `W`-bit result one bit per clock, starting at the most significant bit. A conversion is one sample cycle followed by `W` trial cycles. During each trial the DAC code is the partial approximation held so far, with the bit under test set to 1 as a guess.

A conversion starts from a one-cycle `start` request or from a level `run` input that repeats conversions for as long as it is high. The finished code is presented in the sample cycle of the next conversion, and the working register is cleared in that same cycle. With `run` held high, conversions therefore follow each other with no idle cycle: one result every `W+1` clocks.

The result leaves the block as a push-only stream. `result_vld` is a one-cycle strobe and there is no ready input, so no back-pressure is possible. A consumer must capture `result` in the cycle the strobe is high, or at any later cycle before the next strobe, because the value holds until then.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and `dac_code` to zero, drops `result_vld`, and leaves the block in the sample cycle with `sh_sample` high. This applies even in the middle of a conversion.
- R2: In a sample cycle `sh_sample` is 1 and `dac_code` is 0. The block stays in the sample cycle until `start` or `run` is high at the clock edge that ends it.
- R3: After a sample cycle that ends with `start` or `run` high, `sh_sample` is 0 for exactly `W` cycles and then returns to 1.
- R4: The first trial cycle drives `dac_code` with only bit `W-1` set, which is half scale.
- R5: At the edge that ends a trial, `cmp_hi`=1 (input at or above the DAC code) keeps the trial bit and `cmp_hi`=0 clears it. The next lower bit is then set as the new guess. The second trial therefore drives the top two bits as `11` (three-quarter scale) when the input is at or above half scale, and as `01` (quarter scale) otherwise.
- R6: For an ideal comparator, `result` equals the held input code for every code from 0 to 2^W-1. It appears in the sample cycle that follows the last trial.
- R7: `result_vld` is high for exactly one cycle per conversion, in the cycle where `result` takes its new value. `result` does not change in any other cycle.
- R8: With `run` held high, a new sample cycle follows the last trial directly, so strobes come every `W+1` cycles.
- R9: `start` or `run` asserted during trial cycles has no effect on the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-shot conversion request, seen at the end of a sample cycle |
| run | input | 1 | Level request: convert back to back while high |
| cmp_hi | input | 1 | Comparator decision: 1 when the held input is greater than or equal to the DAC output |
| sh_sample | output | 1 | Sample/hold control: 1 = track, 0 = hold |
| dac_code | output | W | Current partial approximation fed to the DAC |
| result | output | W | Last completed conversion code |
| result_vld | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The assertions assume that `cmp_hi` is settled before each clock edge, and that the held input stays constant from the sample-ending edge until the last trial edge. They also assume `W` is at least 2. The bench models the comparator as a combinational compare of an integer input against `dac_code`. It changes that input only at the falling edge inside a sample cycle, so the value stays fixed for the whole hold window. Both request inputs are driven on falling edges, and the bench deliberately pulses `start` during trials to show that requests are ignored there.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_TRIAL  = 1'b1
  } phase_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  output sar_pkg::phase_t   phase,
  output logic [IW-1:0]     bit_idx,
  output logic              go,
  output logic              last_trial
);
  import sar_pkg::*;

  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  assign go         = (phase == PH_SAMPLE) && (start || run);
  assign last_trial = (phase == PH_TRIAL) && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SAMPLE;
      bit_idx <= TOP_IDX;
    end else begin
      unique case (phase)
        PH_SAMPLE: begin
          bit_idx <= TOP_IDX;
          if (start || run) phase <= PH_TRIAL;
        end
        PH_TRIAL: begin
          if (bit_idx == '0) begin
            phase   <= PH_SAMPLE;
            bit_idx <= TOP_IDX;
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: phase <= PH_SAMPLE;
      endcase
    end
  end

  AST_GO_ENTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
    go |=> (phase == PH_TRIAL) && (bit_idx == TOP_IDX)); // R3
  AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (rst)
    last_trial |=> (phase == PH_SAMPLE)); // R3
  AST_TRIAL_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TRIAL && bit_idx != '0) |=> (phase == PH_TRIAL) && (bit_idx == $past(bit_idx) - 1'b1)); // R9
  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAMPLE && !start && !run) |=> (phase == PH_SAMPLE)); // R2
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  sar_pkg::phase_t   phase,
  input  logic [IW-1:0]     bit_idx,
  input  logic              go,
  input  logic              last_trial,
  input  logic              cmp_hi,
  output logic [W-1:0]      approx,
  output logic [W-1:0]      final_code
);
  import sar_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        approx[b] <= 1'b0;
      end else if (phase == PH_SAMPLE) begin
        approx[b] <= go && (b == W - 1);
      end else if (last_trial) begin
        approx[b] <= 1'b0;
      end else if (bit_idx == IW'(b)) begin
        approx[b] <= cmp_hi;
      end else if (bit_idx == IW'(b + 1)) begin
        approx[b] <= 1'b1;
      end
    end
  end

  assign final_code = (approx & ~W'(1)) | W'(cmp_hi);

  AST_CLEAR_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_trial |=> (approx == '0)); // R2
  AST_SINGLE_GUESS_MSB: assert property (@(posedge clk) disable iff (rst)
    go |=> ($countones(approx) == 1) && approx[W-1]); // R4
endmodule

// File: rtl/sar_out.sv
module sar_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] code,
  output logic [W-1:0] result,
  output logic         result_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      result_vld <= load;
      if (load) result <= code;
    end
  end

  AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (rst)
    !result_vld |-> $stable(result)); // R7
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic         cmp_hi,
  output logic         sh_sample,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result,
  output logic         result_vld
);
  import sar_pkg::*;

  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] HALF = W'(1) << (W - 1);

  phase_t          phase;
  logic [IW-1:0]   bit_idx;
  logic            go;
  logic            last_trial;
  logic [W-1:0]    approx;
  logic [W-1:0]    final_code;

  sar_seq #(.W(W), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .run(run),
    .phase(phase), .bit_idx(bit_idx), .go(go), .last_trial(last_trial)
  );

  sar_shift #(.W(W), .IW(IW)) u_shift (
    .clk(clk), .rst(rst), .phase(phase), .bit_idx(bit_idx), .go(go),
    .last_trial(last_trial), .cmp_hi(cmp_hi),
    .approx(approx), .final_code(final_code)
  );

  sar_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .load(last_trial), .code(final_code),
    .result(result), .result_vld(result_vld)
  );

  assign sh_sample = (phase == PH_SAMPLE);
  assign dac_code  = approx;

  AST_SAMPLE_DAC_ZERO: assert property (@(posedge clk) disable iff (rst)
    sh_sample |-> (dac_code == '0)); // R2
  AST_FIRST_TRIAL_HALF: assert property (@(posedge clk) disable iff (rst)
    (sh_sample && (start || run)) |=> (!sh_sample && dac_code == HALF)); // R4
  AST_DECISION_DIR: assert property (@(posedge clk) disable iff (rst)
    (!sh_sample && !last_trial) |=>
      ($past(cmp_hi) ? (dac_code > $past(dac_code)) : (dac_code < $past(dac_code)))); // R5
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> !result_vld); // R7
  AST_VLD_IN_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    result_vld |-> sh_sample); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (result_vld && run) |=> !sh_sample); // R8
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  localparam int W = 6;
  localparam int NCODE = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic run = 1'b0;
  logic cmp_hi;
  logic sh_sample;
  logic [W-1:0] dac_code;
  logic [W-1:0] result;
  logic result_vld;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign cmp_hi = (vin >= int'(dac_code));

  sar_conv_ctrl #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .run(run), .cmp_hi(cmp_hi),
    .sh_sample(sh_sample), .dac_code(dac_code), .result(result),
    .result_vld(result_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state(input string req);
    chk(sh_sample == 1'b1, req, int'(sh_sample), 1);
    chk(result_vld == 1'b0, req, int'(result_vld), 0);
    chk(result == '0, req, int'(result), 0);
    chk(dac_code == '0, req, int'(dac_code), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state("R1");

    // R2: idle sampling without a request
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(sh_sample == 1'b1 && dac_code == '0, "R2", int'(dac_code), 0);
      chk(result_vld == 1'b0, "R2", int'(result_vld), 0);
    end

    // single start, with a stray start mid-conversion (R9)
    for (int t = 0; t < 2; t++) begin
      automatic int v = (t == 0) ? 45 : 13;
      vin = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(sh_sample == 1'b0, "R3", int'(sh_sample), 0);
      chk(int'(dac_code) == NCODE / 2, "R4", int'(dac_code), NCODE / 2);
      @(negedge clk);
      chk(int'(dac_code) == ((v >= NCODE / 2) ? 3 * NCODE / 4 : NCODE / 4), "R5",
          int'(dac_code), (v >= NCODE / 2) ? 3 * NCODE / 4 : NCODE / 4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 3; k <= W; k++) begin
        chk(sh_sample == 1'b0, "R9", int'(sh_sample), 0);
        if (k < W) @(negedge clk);
      end
      @(negedge clk);
      chk(result_vld == 1'b1 && sh_sample == 1'b1, "R6", int'(result_vld), 1);
      chk(int'(result) == v, "R6", int'(result), v);
      @(negedge clk);
      chk(result_vld == 1'b0, "R7", int'(result_vld), 0);
      chk(int'(result) == v, "R7", int'(result), v);
      chk(sh_sample == 1'b1, "R9", int'(sh_sample), 1);
    end

    // R8/R6: continuous run over every code
    run = 1'b1;
    for (int c = 0; c < NCODE; c++) begin
      vin = c;
      chk(sh_sample == 1'b1, "R8", int'(sh_sample), 1);
      if (c > 0) begin
        chk(result_vld == 1'b1, "R8", int'(result_vld), 1);
        chk(int'(result) == c - 1, "R6", int'(result), c - 1);
      end
      @(negedge clk);
      chk(result_vld == 1'b0, "R7", int'(result_vld), 0);
      repeat (W) @(negedge clk);
    end
    chk(result_vld == 1'b1 && int'(result) == NCODE - 1, "R6", int'(result), NCODE - 1);
    run = 1'b0;
    @(negedge clk);

    // R1: reset in the middle of a conversion
    vin = 50;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule